// File: doc/BRIEF.md
# Segmented Ring Data Arbiter

This block decides which pending data transfers may start on a set of unidirectional rings that link twelve stops. Half of the rings carry data toward increasing stop numbers, the other half toward decreasing numbers. Each stop raises a one-cycle request strobe together with a destination stop. The arbiter routes each transfer the short way round. It looks for a ring of that direction on which every hop segment between source and destination is free. It then reserves those segments for the length of the transfer and returns a one-cycle grant to the source, which carries the ring index. Disjoint transfers may share a ring, so one ring can carry several transfers at the same time.

A request passes through a two-stage request path and is then held as pending at its source until it wins. The decision is registered and delayed through the grant path. Contention among sources is settled by a rotating priority pointer. Each ring also obeys a minimum spacing between starts. While a source already has a pending request, further strobes from that source are dropped. Datapath, flow control and command handling belong to neighbouring blocks.

Top module: `seg_ring_arbiter`

## Requirements
- R1: After reset, no grant is asserted until a valid request has been made.
- R2: An uncontended request strobed in cycle c produces a grant pulse of exactly one cycle in cycle c+3 at its source.
- R3: Ring indices 0 and 1 move data from stop k to stop k+1 (mod 12). A request whose forward hop count (dst-src mod 12) is below 6 is granted only on ring 0 or 1, the lower index first.
- R4: Ring indices 2 and 3 move data from stop k to stop k-1. A request whose forward hop count is above 6 is granted only on ring 2 or 3, the lower index first.
- R5: For a forward hop count of exactly 6, rings are tried in the order 0, 1, 2, 3, and the first usable ring is granted.
- R6: A ring is granted only when none of the segments on the path is reserved. Otherwise the request stays pending and is granted later.
- R7: A grant reserves its path segments for 9 cycles counted from the decision. A waiting request on the same segments is decided in the cycle the reservation expires, so its grant pulse comes 9 cycles after the earlier one.
- R8: A ring starts at most one transfer every 3 cycles, and up to 3 disjoint transfers may be active on one ring at once.
- R9: When several pending sources compete in one cycle, they are served in rotating order. The search starts at the stop one past the first winner of the last cycle that issued a grant, and it starts at stop 0 after reset.
- R10: A request whose destination equals its source, or is not a valid stop (12 to 15), is dropped and never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 12 | One-cycle request strobe per source stop |
| req_dst | input | 48 | Destination stop per source, 4 bits each, source k at bits 4k+3..4k |
| gnt_valid | output | 12 | One-cycle grant pulse per source stop |
| gnt_ring | output | 24 | Granted ring index per source, 2 bits each, source k at bits 2k+1..2k |

## Verification
An uncontended grant is due exactly three cycles after the strobe cycle. A request held back by reserved segments is due nine cycles after the grant that blocked it. Starts on one ring are spaced three cycles apart. A bench monitor samples the grant lines on the falling edge and records the cycle number and ring of every pulse. Each scenario waits until well past the last expected pulse before it compares these records with the cycle numbers computed from the strobe cycle, so a grant that comes one cycle early or late, comes on the wrong ring, or comes twice is caught.

// File: rtl/segring_pkg.sv
`timescale 1ns/1ps
package segring_pkg;

  typedef enum logic [1:0] {
    ROUTE_FWD    = 2'd0,
    ROUTE_REV    = 2'd1,
    ROUTE_EITHER = 2'd2
  } route_e;

  // hops needed going toward increasing stop numbers
  function automatic int fwd_hops(input int src, input int dst, input int n);
    return (dst + n - src) % n;
  endfunction

  // shortest direction; a half-ring distance allows both
  function automatic route_e pick_route(input int src, input int dst, input int n);
    int h;
    h = fwd_hops(src, dst, n);
    if (2 * h < n)      return ROUTE_FWD;
    else if (2 * h > n) return ROUTE_REV;
    else                return ROUTE_EITHER;
  endfunction

endpackage

// File: rtl/seg_req_stage.sv
`timescale 1ns/1ps
module seg_req_stage #(
  parameter int N_STOPS = 12,
  parameter int IDW     = 4,
  parameter int REQ_LAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_STOPS-1:0]     req_valid,
  input  logic [N_STOPS*IDW-1:0] req_dst,
  input  logic [N_STOPS-1:0]     take,
  output logic [N_STOPS-1:0]     pend_v,
  output logic [N_STOPS*IDW-1:0] pend_dst
);
  localparam int NS = REQ_LAT - 1;

  logic [N_STOPS-1:0]     accept_in;
  logic [N_STOPS-1:0]     sv_q [NS];
  logic [N_STOPS*IDW-1:0] sd_q [NS];

  // self-addressed or out-of-range destinations never enter the pipe
  always_comb begin
    for (int i = 0; i < N_STOPS; i++) begin
      accept_in[i] = req_valid[i]
                   && (int'(req_dst[i*IDW +: IDW]) != i)
                   && (int'(req_dst[i*IDW +: IDW]) < N_STOPS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) begin
        sv_q[k] <= '0;
        sd_q[k] <= '0;
      end
      pend_v   <= '0;
      pend_dst <= '0;
    end else begin
      sv_q[0] <= accept_in;
      sd_q[0] <= req_dst;
      for (int k = 1; k < NS; k++) begin
        sv_q[k] <= sv_q[k-1];
        sd_q[k] <= sd_q[k-1];
      end
      for (int i = 0; i < N_STOPS; i++) begin
        if (take[i]) begin
          pend_v[i] <= 1'b0;
        end else if (!pend_v[i] && sv_q[NS-1][i]) begin
          pend_v[i]                  <= 1'b1;
          pend_dst[i*IDW +: IDW]     <= sd_q[NS-1][i*IDW +: IDW];
        end
      end
    end
  end

  for (genvar i = 0; i < N_STOPS; i++) begin : g_chk
    // R10: a self-addressed strobe leaves no trace in the request pipe
    a_r10_self_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && int'(req_dst[i*IDW +: IDW]) == i) |=> !sv_q[0][i]);
  end

endmodule

// File: rtl/seg_ring_track.sv
`timescale 1ns/1ps
module seg_ring_track #(
  parameter int N_STOPS   = 12,
  parameter int HOLD      = 9,
  parameter int START_GAP = 3,
  parameter int MAX_ACT   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [N_STOPS-1:0] start_mask,
  output logic [N_STOPS-1:0] busy,
  output logic               can_start
);
  localparam int CW = $clog2(HOLD + 1);
  localparam int GW = $clog2(START_GAP + 1);

  logic [CW-1:0]      cnt_q  [MAX_ACT];
  logic [N_STOPS-1:0] mask_q [MAX_ACT];
  logic [GW-1:0]      gap_q;
  logic [MAX_ACT-1:0] slot_free;
  logic [MAX_ACT-1:0] slot_load;
  logic               placed;

  // a slot in its last reserved cycle counts as free (same-cycle reuse)
  always_comb begin
    busy      = '0;
    slot_load = '0;
    placed    = 1'b0;
    for (int k = 0; k < MAX_ACT; k++) begin
      slot_free[k] = (cnt_q[k] <= CW'(1));
      if (!slot_free[k]) busy = busy | mask_q[k];
    end
    for (int k = 0; k < MAX_ACT; k++) begin
      if (start && slot_free[k] && !placed) begin
        slot_load[k] = 1'b1;
        placed       = 1'b1;
      end
    end
    can_start = (gap_q == '0) && (|slot_free);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_ACT; k++) begin
        cnt_q[k]  <= '0;
        mask_q[k] <= '0;
      end
      gap_q <= '0;
    end else begin
      for (int k = 0; k < MAX_ACT; k++) begin
        if (slot_load[k]) begin
          cnt_q[k]  <= CW'(HOLD);
          mask_q[k] <= start_mask;
        end else if (cnt_q[k] != '0) begin
          cnt_q[k] <= cnt_q[k] - CW'(1);
        end
      end
      if (start)              gap_q <= GW'(START_GAP - 1);
      else if (gap_q != '0)   gap_q <= gap_q - GW'(1);
    end
  end

  // R6: a new reservation never lands on a segment still held
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ((start_mask & busy) == '0));

  // R8: room was available when the ring started
  a_r8_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($countones(slot_free) >= 1));

  if (START_GAP > 1) begin : g_gap
    // R8: no two starts on adjacent cycles
    a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
  end

  if (HOLD > 1) begin : g_hold
    // R7: the segments just granted are reported busy on the next cycle
    a_r7_held: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (($past(start_mask) & ~busy) == '0));
  end

endmodule

// File: rtl/seg_pick.sv
`timescale 1ns/1ps
module seg_pick
  import segring_pkg::*;
#(
  parameter int N_STOPS = 12,
  parameter int N_RINGS = 4,
  parameter int IDW     = 4,
  parameter int RW      = 2
) (
  input  logic [N_STOPS-1:0]         pend_v,
  input  logic [N_STOPS*IDW-1:0]     pend_dst,
  input  logic [IDW-1:0]             rr_ptr,
  input  logic [N_RINGS*N_STOPS-1:0] busy,
  input  logic [N_RINGS-1:0]         can_start,
  output logic [N_STOPS-1:0]         take,
  output logic [N_STOPS*RW-1:0]      take_ring,
  output logic [N_RINGS-1:0]         ring_start,
  output logic [N_RINGS*N_STOPS-1:0] ring_mask,
  output logic                       rr_adv,
  output logic [IDW-1:0]             rr_next
);
  localparam int HALF = N_RINGS / 2;

  // segment k of a forward ring joins stop k to k+1; of a reverse ring, k to k-1
  function automatic logic [N_STOPS-1:0] path_mask(input int src, input int dst,
                                                   input logic fwd);
    logic [N_STOPS-1:0] m;
    int h;
    m = '0;
    h = fwd ? fwd_hops(src, dst, N_STOPS) : fwd_hops(dst, src, N_STOPS);
    for (int k = 0; k < N_STOPS; k++) begin
      if (k < h) begin
        if (fwd) m[(src + k) % N_STOPS] = 1'b1;
        else     m[(src + N_STOPS - k) % N_STOPS] = 1'b1;
      end
    end
    return m;
  endfunction

  int                 s;
  int                 d;
  route_e             rt;
  logic               got;
  logic               fwd;
  logic               dir_ok;
  logic [N_STOPS-1:0] m;

  always_comb begin
    take       = '0;
    take_ring  = '0;
    ring_start = '0;
    ring_mask  = '0;
    rr_adv     = 1'b0;
    rr_next    = rr_ptr;
    s = 0; d = 0; rt = ROUTE_FWD; got = 1'b0; fwd = 1'b0; dir_ok = 1'b0; m = '0;
    for (int o = 0; o < N_STOPS; o++) begin
      s   = (int'(rr_ptr) + o) % N_STOPS;
      got = 1'b0;
      if (pend_v[s]) begin
        d  = int'(pend_dst[s*IDW +: IDW]);
        rt = pick_route(s, d, N_STOPS);
        for (int r = 0; r < N_RINGS; r++) begin
          fwd    = (r < HALF);
          dir_ok = (rt == ROUTE_EITHER) || ((rt == ROUTE_FWD) == fwd);
          m      = path_mask(s, d, fwd);
          if (!got && dir_ok && can_start[r] && !ring_start[r]
              && ((m & busy[r*N_STOPS +: N_STOPS]) == '0)) begin
            got                         = 1'b1;
            take[s]                     = 1'b1;
            take_ring[s*RW +: RW]       = RW'(r);
            ring_start[r]               = 1'b1;
            ring_mask[r*N_STOPS +: N_STOPS] = m;
          end
        end
        if (got && !rr_adv) begin
          rr_adv  = 1'b1;
          rr_next = IDW'((s + 1) % N_STOPS);
        end
      end
    end
  end

endmodule

// File: rtl/seg_gnt_pipe.sv
`timescale 1ns/1ps
module seg_gnt_pipe #(
  parameter int N_STOPS = 12,
  parameter int RW      = 2,
  parameter int GNT_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_STOPS-1:0]    d_valid,
  input  logic [N_STOPS*RW-1:0] d_ring,
  output logic [N_STOPS-1:0]    q_valid,
  output logic [N_STOPS*RW-1:0] q_ring
);
  logic [N_STOPS-1:0]    v_q [GNT_LAT];
  logic [N_STOPS*RW-1:0] r_q [GNT_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < GNT_LAT; k++) begin
        v_q[k] <= '0;
        r_q[k] <= '0;
      end
    end else begin
      v_q[0] <= d_valid;
      r_q[0] <= d_ring;
      for (int k = 1; k < GNT_LAT; k++) begin
        v_q[k] <= v_q[k-1];
        r_q[k] <= r_q[k-1];
      end
    end
  end

  assign q_valid = v_q[GNT_LAT-1];
  assign q_ring  = r_q[GNT_LAT-1];

endmodule

// File: rtl/seg_ring_arbiter.sv
`timescale 1ns/1ps
module seg_ring_arbiter
  import segring_pkg::*;
#(
  parameter int N_STOPS    = 12,
  parameter int N_RINGS    = 4,
  parameter int XFER_BEATS = 8,
  parameter int REQ_LAT    = 2,
  parameter int GNT_LAT    = 2,
  parameter int START_GAP  = 3,
  parameter int MAX_ACTIVE = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_STOPS-1:0]                req_valid,
  input  logic [N_STOPS*$clog2(N_STOPS)-1:0] req_dst,
  output logic [N_STOPS-1:0]                gnt_valid,
  output logic [N_STOPS*$clog2(N_RINGS)-1:0] gnt_ring
);
  localparam int IDW  = $clog2(N_STOPS);
  localparam int RW   = $clog2(N_RINGS);
  localparam int HOLD = GNT_LAT - 1 + XFER_BEATS;
  localparam int HALF = N_RINGS / 2;

  logic [N_STOPS-1:0]         pend_v;
  logic [N_STOPS*IDW-1:0]     pend_dst;
  logic [N_STOPS-1:0]         take;
  logic [N_STOPS*RW-1:0]      take_ring;
  logic [N_RINGS-1:0]         ring_start;
  logic [N_RINGS-1:0]         can_start;
  logic [N_RINGS*N_STOPS-1:0] ring_mask;
  logic [N_RINGS*N_STOPS-1:0] busy;
  logic [IDW-1:0]             rr_q;
  logic [IDW-1:0]             rr_next;
  logic                       rr_adv;

  seg_req_stage #(.N_STOPS(N_STOPS), .IDW(IDW), .REQ_LAT(REQ_LAT)) u_req (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .take(take), .pend_v(pend_v), .pend_dst(pend_dst)
  );

  seg_pick #(.N_STOPS(N_STOPS), .N_RINGS(N_RINGS), .IDW(IDW), .RW(RW)) u_pick (
    .pend_v(pend_v), .pend_dst(pend_dst), .rr_ptr(rr_q), .busy(busy),
    .can_start(can_start), .take(take), .take_ring(take_ring),
    .ring_start(ring_start), .ring_mask(ring_mask),
    .rr_adv(rr_adv), .rr_next(rr_next)
  );

  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    seg_ring_track #(.N_STOPS(N_STOPS), .HOLD(HOLD), .START_GAP(START_GAP),
                     .MAX_ACT(MAX_ACTIVE)) u_trk (
      .clk(clk), .rst_n(rst_n), .start(ring_start[r]),
      .start_mask(ring_mask[r*N_STOPS +: N_STOPS]),
      .busy(busy[r*N_STOPS +: N_STOPS]), .can_start(can_start[r])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rr_q <= '0;
    else if (rr_adv) rr_q <= rr_next;
  end

  seg_gnt_pipe #(.N_STOPS(N_STOPS), .RW(RW), .GNT_LAT(GNT_LAT)) u_gnt (
    .clk(clk), .rst_n(rst_n), .d_valid(take), .d_ring(take_ring),
    .q_valid(gnt_valid), .q_ring(gnt_ring)
  );

  for (genvar i = 0; i < N_STOPS; i++) begin : g_chk
    // R2: one decision per request, never on two cycles in a row
    a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      take[i] |=> !take[i]);
    // R6: a winner had a live pending request, and it is consumed
    a_r6_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
      take[i] |-> pend_v[i]);
    a_r6_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      take[i] |=> !pend_v[i]);
    // R3: forward rings only for paths no longer than half the ring
    a_r3_fwd_short: assert property (@(posedge clk) disable iff (!rst_n)
      (take[i] && int'(take_ring[i*RW +: RW]) < HALF)
        |-> (2 * fwd_hops(i, int'(pend_dst[i*IDW +: IDW]), N_STOPS) <= N_STOPS));
    // R4: reverse rings only when the reverse way is no longer
    a_r4_rev_short: assert property (@(posedge clk) disable iff (!rst_n)
      (take[i] && int'(take_ring[i*RW +: RW]) >= HALF)
        |-> (2 * fwd_hops(i, int'(pend_dst[i*IDW +: IDW]), N_STOPS) >= N_STOPS));
    // R10: no grant for a self-addressed destination
    a_r10_no_self: assert property (@(posedge clk) disable iff (!rst_n)
      take[i] |-> (int'(pend_dst[i*IDW +: IDW]) != i));
  end

  // R8: at most one start per ring in a cycle, at most one per source
  a_r8_ring_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_start) == $countones(take));

endmodule

// File: tb/test_seg_ring_arbiter.sv
`timescale 1ns/1ps
module test_seg_ring_arbiter;
  localparam int N = 12, IDW = 4, RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]     rv = '0;
  logic [N*IDW-1:0] rd = '0;
  logic [N-1:0]     gv;
  logic [N*RW-1:0]  gr;

  int cyc = 0, n_chk = 0, n_err = 0;
  int g_cyc [N];
  int g_ring[N];
  int g_cnt [N];

  seg_ring_arbiter i_seg_ring_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_dst(rd),
    .gnt_valid(gv), .gnt_ring(gr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (gv[i]) begin
          g_cyc[i]  = cyc;
          g_ring[i] = int'(gr[i*RW +: RW]);
          g_cnt[i]  = g_cnt[i] + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_gnt(input int node, input int ring, input int at, input string tag);
    n_chk++;
    if (g_cnt[node] != 1 || g_ring[node] != ring || g_cyc[node] != at) begin
      n_err++;
      $display("FAIL %s: node %0d actual count=%0d ring=%0d cycle=%0d expected count=1 ring=%0d cycle=%0d",
               tag, node, g_cnt[node], g_ring[node], g_cyc[node], ring, at);
    end
  endtask

  function automatic int total_grants();
    int t = 0;
    for (int i = 0; i < N; i++) t += g_cnt[i];
    return t;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    rv    = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      g_cyc[i] = -1; g_ring[i] = -1; g_cnt[i] = 0;
    end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_req(input int s, input int d);
    rv[s]              = 1'b1;
    rd[s*IDW +: IDW]   = IDW'(d);
  endtask

  // called at a falling edge with requests set; returns the strobe cycle
  task automatic fire(output int rc);
    rc = cyc + 1;
    @(negedge clk);
    rv = '0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic t_reset_idle();
    do_reset();
    repeat (10) @(negedge clk);
    check(total_grants() == 0, "R1 no grant after reset", total_grants(), 0);
  endtask

  task automatic t_forward();
    int rc;
    do_reset();
    @(negedge clk); set_req(0, 3); fire(rc);
    wait_to(rc + 16);
    expect_gnt(0, 0, rc + 3, "R2 R3 forward path latency and ring");
    check(total_grants() == 1, "R2 single pulse", total_grants(), 1);
  endtask

  task automatic t_reverse();
    int rc;
    do_reset();
    @(negedge clk); set_req(5, 2); fire(rc);
    wait_to(rc + 8);
    expect_gnt(5, 2, rc + 3, "R4 reverse path ring");
  endtask

  task automatic t_half_ring();
    int rc;
    do_reset();
    @(negedge clk); set_req(0, 6); set_req(1, 7); set_req(2, 8); fire(rc);
    wait_to(rc + 8);
    expect_gnt(0, 0, rc + 3, "R5 tie first ring");
    expect_gnt(1, 1, rc + 3, "R5 tie second ring");
    expect_gnt(2, 2, rc + 3, "R5 tie falls to reverse ring");
  endtask

  task automatic t_rotate_release();
    int rc1, rc2;
    do_reset();
    @(negedge clk); set_req(4, 5); fire(rc1);
    wait_to(rc1 + 15);
    expect_gnt(4, 0, rc1 + 3, "R9 pointer setup grant");
    @(negedge clk); set_req(11, 4); set_req(1, 4); set_req(2, 4); fire(rc2);
    wait_to(rc2 + 20);
    expect_gnt(11, 0, rc2 + 3, "R9 rotated winner first");
    expect_gnt(1, 1, rc2 + 3, "R9 second winner");
    expect_gnt(2, 0, rc2 + 12, "R6 R7 blocked then granted at release");
  endtask

  task automatic t_start_spacing();
    int rc;
    do_reset();
    @(negedge clk);
    for (int k = 0; k < 6; k++) set_req(2 * k, 2 * k + 1);
    fire(rc);
    wait_to(rc + 16);
    expect_gnt(0, 0, rc + 3, "R8 first start ring0");
    expect_gnt(2, 1, rc + 3, "R8 first start ring1");
    expect_gnt(4, 0, rc + 6, "R8 second start ring0");
    expect_gnt(6, 1, rc + 6, "R8 second start ring1");
    expect_gnt(8, 0, rc + 9, "R8 third concurrent on ring0");
    expect_gnt(10, 1, rc + 9, "R8 third concurrent on ring1");
  endtask

  task automatic t_self();
    int rc;
    do_reset();
    @(negedge clk); set_req(4, 4); set_req(7, 14); fire(rc);
    wait_to(rc + 14);
    check(total_grants() == 0, "R10 self or invalid destination dropped", total_grants(), 0);
    @(negedge clk); set_req(4, 5); fire(rc);
    wait_to(rc + 8);
    expect_gnt(4, 0, rc + 3, "R10 later valid request from same stop");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_forward();
    t_reverse();
    t_half_ring();
    t_rotate_release();
    t_start_spacing();
    t_self();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule